// File: doc/BRIEF.md
# Dual-Clock Periodic Wakeup Timer

This block is a 32-bit down-counting wakeup timer. Its software-visible registers run on a fast bus clock, and its counter runs on a separate slow timer clock that has no fixed phase relation to the bus clock. Software writes a load value and a control word. Each write is held in the bus domain. A toggle handshake then carries the write across a two-flop synchronizer, and the timer domain copies the whole held word at one timer edge. A write is therefore never seen half-updated, and it takes effect only after several timer clocks. A status bit shows when a crossing is still in flight. While that bit is set, further writes to the load or control register are dropped.

Each timeout toggles a flag in the timer domain. The bus domain synchronizes that flag and turns each change into a sticky pending bit. Software clears the pending bit by writing any value to a clear register. The interrupt line is the pending bit ANDed with a one-bit mask, and the mask has its own set and clear registers. The register port is a plain single-cycle write strobe with combinational read data. The port has no back-pressure: a write is always taken in the cycle its strobe is high, although a write to the load or control register made during a crossing has no effect.

Top module: `wake_timer`

## Requirements
- R1: After reset, the load (address 0), control (address 1), status (address 2) and mask (address 4) registers read as zero, and `irq` is low.
- R2: A write to the load or control register sets status bit 0 (busy) from the next bus cycle. Busy stays set while at least two rising edges of `tmr_clk` occur, and then it clears by itself.
- R3: A write to address 0 or 1 while busy is set has no effect, and the register keeps its previous readback value.
- R4: The control register fields are: bit 0 enable, bit 1 source select, bits 3:2 prescaler select, bit 4 periodic. The counter is loaded with the load value when a load-register write crosses. With source 0 and prescaler 00 in periodic mode, a timeout occurs every load+1 timer clocks.
- R5: The prescaler select codes divide by 1 (00), 16 (01), 256 (10) or 32768 (11). In periodic mode the timeout period is (load+1) times the divisor, counted in timer clocks.
- R6: With bit 1 set, the prescaler and counter advance only on timer clocks where `lp_tick` is high.
- R7: With bit 4 clear (free-running), the counter wraps to all ones after a timeout, so no second timeout follows within the next 100 ticks.
- R8: Once a write of zero to the control register has crossed (busy has cleared), no further timeout occurs.
- R9: A timeout sets status bit 1 (pending). Pending stays set until any value is written to address 3.
- R10: `irq` is high exactly when pending and the mask are both set. Any write to address 4 sets the mask, any write to address 5 clears it, and the mask reads back at bit 0 of address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-domain clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| tmr_clk | input | 1 | Counter-domain clock, asynchronous to bus_clk |
| tmr_rst_n | input | 1 | Active-low reset, timer domain |
| lp_tick | input | 1 | Count enable in the timer domain when the alternate source is selected |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Masked timeout interrupt request |

## Verification
The assertions take as given that both resets are applied together and that `lp_tick` changes only in step with `tmr_clk`. They also take as given that the held load and control words remain stable until the timer domain has acknowledged them, which the busy-drop rule guarantees. The stimulus drives `lp_tick` on the falling timer edge, and it waits for busy to clear before each new configuration write, except in the scenario that deliberately writes during a crossing. Period measurements use a timer clock of 70 ns against a 10 ns bus clock. This keeps the drift of the return-path latency well under one timer period, so counts of timer edges between two pending flags are exact.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int CTRL_W = 5;

  typedef struct packed {
    logic       periodic;
    logic [1:0] psel;
    logic       src_lp;
    logic       en;
  } wt_ctrl_t;

  localparam logic [2:0] ADR_LOAD = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam logic [2:0] ADR_STAT = 3'd2;
  localparam logic [2:0] ADR_ICLR = 3'd3;
  localparam logic [2:0] ADR_MSET = 3'd4;
  localparam logic [2:0] ADR_MCLR = 3'd5;

  localparam int PSC_W = 15;

  function automatic logic [PSC_W-1:0] psc_last(input logic [1:0] sel);
    case (sel)
      2'b00:   psc_last = PSC_W'(0);
      2'b01:   psc_last = PSC_W'(15);
      2'b10:   psc_last = PSC_W'(255);
      default: psc_last = PSC_W'(32767);
    endcase
  endfunction
endpackage

// File: rtl/wt_sync2.sv
module wt_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wt_tmr_core.sv
module wt_tmr_core
  import wt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          tmr_clk,
  input  logic          rst_n,
  input  logic          lp_tick,
  input  logic          req_t,
  input  logic [DW-1:0] held_load,
  input  wt_ctrl_t      held_ctrl,
  input  logic          held_ldf,
  output logic          ack_t,
  output logic          ev_t
);
  logic          req_s, req_seen, apply;
  wt_ctrl_t      ctrl_q;
  logic [DW-1:0] load_q, cnt;
  logic [PSC_W-1:0] psc;
  logic          step, wrap;

  wt_sync2 #(.W(1)) u_req (.clk(tmr_clk), .rst_n(rst_n), .d(req_t), .q(req_s));

  assign apply = req_s ^ req_seen;
  assign step  = ctrl_q.en && (ctrl_q.src_lp ? lp_tick : 1'b1);
  assign wrap  = (psc == psc_last(ctrl_q.psel));
  assign ack_t = req_seen;

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      ctrl_q   <= '0;
      load_q   <= '0;
      cnt      <= '0;
      psc      <= '0;
      ev_t     <= 1'b0;
    end else if (apply) begin
      req_seen <= req_s;
      ctrl_q   <= held_ctrl;
      load_q   <= held_load;
      psc      <= '0;
      if (held_ldf) cnt <= held_load;
    end else if (step) begin
      if (wrap) begin
        psc <= '0;
        if (cnt == '0) begin
          ev_t <= ~ev_t;
          cnt  <= ctrl_q.periodic ? load_q : '1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        psc <= psc + 1'b1;
      end
    end
  end

  // R5
  psc_range_chk: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    psc <= psc_last(ctrl_q.psel));

  // R2
  shadow_stable_chk: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    !apply |=> $stable(ctrl_q) && $stable(load_q));

  // R4
  cnt_hold_chk: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (!apply && !(step && wrap)) |=> $stable(cnt));

  // R8
  halt_quiet_chk: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (!ctrl_q.en && !apply) |=> $stable(ev_t));
endmodule

// File: rtl/wt_bus_regs.sv
module wt_bus_regs
  import wt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          bus_clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] held_load,
  output wt_ctrl_t      held_ctrl,
  output logic          held_ldf,
  output logic          req_t,
  input  logic          ack_t,
  input  logic          ev_t,
  output logic          irq
);
  logic ack_s, ev_s, ev_seen, ev_edge, busy;
  logic pending, mask_q;
  logic wr_load, wr_ctrl, wr_iclr;

  wt_sync2 #(.W(2)) u_back (.clk(bus_clk), .rst_n(rst_n),
    .d({ack_t, ev_t}), .q({ack_s, ev_s}));

  assign busy    = req_t ^ ack_s;
  assign ev_edge = ev_s ^ ev_seen;
  assign wr_load = we && (addr == ADR_LOAD) && !busy;
  assign wr_ctrl = we && (addr == ADR_CTRL) && !busy;
  assign wr_iclr = we && (addr == ADR_ICLR);
  assign irq     = pending & mask_q;

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      held_load <= '0;
      held_ctrl <= '0;
      held_ldf  <= 1'b0;
      req_t     <= 1'b0;
      ev_seen   <= 1'b0;
      pending   <= 1'b0;
      mask_q    <= 1'b0;
    end else begin
      ev_seen <= ev_s;
      if (wr_load) begin
        held_load <= wdata;
        held_ldf  <= 1'b1;
        req_t     <= ~req_t;
      end else if (wr_ctrl) begin
        held_ctrl <= wt_ctrl_t'(wdata[CTRL_W-1:0]);
        held_ldf  <= 1'b0;
        req_t     <= ~req_t;
      end
      pending <= (pending && !wr_iclr) || ev_edge;
      if (we && addr == ADR_MSET)      mask_q <= 1'b1;
      else if (we && addr == ADR_MCLR) mask_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_LOAD: rdata = held_load;
      ADR_CTRL: rdata[CTRL_W-1:0] = held_ctrl;
      ADR_STAT: rdata[1:0] = {pending, busy};
      ADR_MSET: rdata[0] = mask_q;
      default:  rdata = '0;
    endcase
  end

  // R3
  held_stable_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    busy |=> $stable(held_load) && $stable(held_ctrl));

  // R9
  iclr_clears_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_iclr && !ev_edge) |=> !pending);

  // R10
  mask_off_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (we && addr == ADR_MCLR) |=> !irq);
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          tmr_clk,
  input  logic          tmr_rst_n,
  input  logic          lp_tick,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [DW-1:0] held_load;
  wt_ctrl_t      held_ctrl;
  logic          held_ldf, req_t, ack_t, ev_t;

  wt_bus_regs #(.DW(DW)) u_regs (
    .bus_clk(bus_clk), .rst_n(bus_rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .held_load(held_load),
    .held_ctrl(held_ctrl), .held_ldf(held_ldf), .req_t(req_t),
    .ack_t(ack_t), .ev_t(ev_t), .irq(irq));

  wt_tmr_core #(.DW(DW)) u_core (
    .tmr_clk(tmr_clk), .rst_n(tmr_rst_n), .lp_tick(lp_tick), .req_t(req_t),
    .held_load(held_load), .held_ctrl(held_ctrl), .held_ldf(held_ldf),
    .ack_t(ack_t), .ev_t(ev_t));
endmodule

// File: tb/sim_wake_timer.sv
module sim_wake_timer;
  logic bus_clk = 0, tmr_clk = 0;
  logic bus_rst_n = 0, tmr_rst_n = 0;
  logic lp_tick = 0, reg_we = 0, irq;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  int n_chk = 0, n_bad = 0, tcnt = 0, bcnt = 0, lpc = 0;

  always #5 bus_clk = ~bus_clk;
  always #35 tmr_clk = ~tmr_clk;
  always @(posedge tmr_clk) tcnt++;
  always @(negedge tmr_clk) begin
    lpc = (lpc == 4) ? 0 : lpc + 1;
    lp_tick <= (lpc == 0);
  end

  wake_timer u0 (.bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .tmr_clk(tmr_clk),
    .tmr_rst_n(tmr_rst_n), .lp_tick(lp_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge bus_clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      @(negedge bus_clk); rd(3'd2, s);
      if (!s[0]) break;
    end
  endtask

  task automatic wait_pend(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge bus_clk); rd(3'd2, s);
      if (s[1]) begin ok = 1; break; end
    end
  endtask

  task automatic quiesce();
    wr(3'd1, 32'h0); wait_idle();
    repeat (10) @(negedge bus_clk);
    wr(3'd3, 32'h0);
  endtask

  task automatic setup(input logic [31:0] ld, input logic [31:0] ctl);
    quiesce();
    wr(3'd0, ld); wait_idle();
    wr(3'd1, ctl); wait_idle();
  endtask

  task automatic period(input string req, input int exp);
    bit ok; int t0;
    wait_pend(ok); t0 = tcnt;
    wr(3'd3, 32'h0);
    wait_pend(ok);
    check(req, ok ? tcnt - t0 : -1, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge bus_clk);
    rd(3'd0, v); check("R1 load", v, 0);
    rd(3'd1, v); check("R1 ctrl", v, 0);
    rd(3'd2, v); check("R1 status", v, 0);
    rd(3'd4, v); check("R1 mask", v, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_latency();
    logic [31:0] s; int t0;
    wr(3'd0, 32'h55); t0 = tcnt;
    rd(3'd2, s); check("R2 busy set", s[0], 1);
    wait_idle();
    check("R2 min crossing", (tcnt - t0) >= 2, 1);
    rd(3'd2, s); check("R2 busy clears", s[0], 0);
  endtask

  task automatic t_busy_drop();
    logic [31:0] v;
    wr(3'd1, 32'h0C);
    wr(3'd1, 32'h13);
    wr(3'd0, 32'h77);
    wait_idle();
    rd(3'd1, v); check("R3 ctrl kept", v, 32'h0C);
    rd(3'd0, v); check("R3 load kept", v, 32'h55);
  endtask

  task automatic t_periodic();
    setup(32'd3, 32'h11); period("R4 load 3", 4);
    setup(32'd6, 32'h11); period("R4 load 6", 7);
  endtask

  task automatic t_prescale();
    setup(32'd1, 32'h15); period("R5 div16", 32);
    setup(32'd0, 32'h19); period("R5 div256", 256);
  endtask

  task automatic t_lp_src();
    setup(32'd1, 32'h13); period("R6 lp source", 10);
  endtask

  task automatic t_free();
    bit ok; logic [31:0] s;
    setup(32'd2, 32'h01);
    wait_pend(ok); check("R7 first timeout", ok, 1);
    wr(3'd3, 32'h0);
    repeat (700) @(negedge bus_clk);
    rd(3'd2, s); check("R7 no repeat", s[1], 0);
  endtask

  task automatic t_halt();
    bit ok; logic [31:0] s;
    setup(32'd2, 32'h11);
    wait_pend(ok); check("R8 running", ok, 1);
    quiesce();
    repeat (700) @(negedge bus_clk);
    rd(3'd2, s); check("R8 halted", s[1], 0);
  endtask

  task automatic t_iclr_mask();
    bit ok; logic [31:0] s;
    setup(32'd1, 32'h11);
    wait_pend(ok);
    wr(3'd1, 32'h0); wait_idle();
    repeat (10) @(negedge bus_clk);
    rd(3'd2, s); check("R9 pending sticky", s[1], 1);
    check("R10 masked", irq, 0);
    wr(3'd4, 32'h0); #1;
    check("R10 irq on", irq, 1);
    rd(3'd4, s); check("R10 mask read", s, 1);
    wr(3'd5, 32'hFF); #1;
    check("R10 irq off", irq, 0);
    wr(3'd4, 32'h0);
    wr(3'd3, 32'hDEAD); #1;
    rd(3'd2, s); check("R9 cleared", s[1], 0);
    check("R10 irq after clear", irq, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge bus_clk) begin
    bcnt++;
    if (bcnt > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge tmr_clk);
    bus_rst_n = 1; tmr_rst_n = 1;
    t_reset();
    t_latency();
    t_busy_drop();
    t_periodic();
    t_prescale();
    t_lp_src();
    t_free();
    t_halt();
    t_iclr_mask();
    finish_run();
  end
endmodule